// File: doc/BRIEF.md
# Fused Multiply-Add Exception and Sign Stage

This stage sits beside the arithmetic datapath of a floating-point unit and handles the special cases of the fused multiply-add family. It takes the instruction word, the three double-precision operands, and the raw fused value from an external arithmetic core. From these it finds three kinds of invalid operation:

- a signalling NaN among the operands,
- zero times infinity in the product step,
- infinity minus infinity in the add step.

The infinity-minus-infinity test uses operand classes and the XOR of the operand signs. It never looks at a rounded intermediate product.

The stage also applies the final sign flip for the negated forms of the operation. A NaN result is never flipped. The result and the per-operation flags are registered and appear one cycle after a valid strobe. Each detected exception is ORed into a sticky status set, which only reset or an explicit clear input can empty.

Rounding to single precision, the arithmetic itself and trap delivery happen elsewhere. For the single-precision forms the stage only reports which form was decoded.

Top module: `fma_special_unit`

## Requirements
- R1: The instruction word is decoded as follows:
  - Bits [31:26] hold the primary opcode: 63 selects the double form and 59 selects the single form.
  - Bits [5:1] hold the extended opcode: 29 is multiply-add, 28 is multiply-subtract, 31 is negative multiply-add and 30 is negative multiply-subtract.
  - Any other combination is illegal. A strobe with an illegal word produces no result strobe and leaves the sticky bits unchanged.
- R2: An operand is a signalling NaN when its 11-bit exponent (bits [62:52]) is all ones, its fraction (bits [51:0]) is nonzero, and fraction bit 51 is zero. The signalling-NaN bit is raised when any of A, C or B is one.
- R3: The zero-times-infinity bit is raised when one of A and C is infinite and the other is zero (either sign).
- R4: The product counts as infinite only when A or C is infinite, neither is zero and neither is a NaN. The product sign is A[63] XOR C[63].
- R5: For multiply-add and negative multiply-add, the infinity-minus-infinity bit is raised when the product is infinite, B is infinite, and the product sign differs from B[63].
- R6: For multiply-subtract and negative multiply-subtract, the infinity-minus-infinity bit is raised when the product is infinite, B is infinite, and the product sign equals B[63].
- R7: The negated forms return the fused value with bit 63 inverted, unless the fused value is a NaN, which passes through unchanged. The non-negated forms return the fused value unchanged.
- R8: A legal strobe loads the result, the single-form flag and the flags on the next rising edge. `res_vld` is high for exactly that one cycle.
- R9: The sticky bits are updated as follows:
  - On a legal strobe, the bits of that operation are ORed into the sticky set.
  - `clr_sticky` empties the set. When a clear and a legal strobe arrive in the same cycle, the set holds only the new operation's bits.
- R10: `op_invalid` is high alongside `res_vld` exactly when any of the three invalid bits was raised by that operation.
- R11: After reset, every output reads zero.
- R12: `res_single` reports 1 for primary opcode 59 and 0 for primary opcode 63 on the result of a legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| clr_sticky | input | 1 | Empties the sticky exception set |
| insn_word | input | 32 | Instruction word in A-form layout |
| opnd_a | input | 64 | Multiplicand A |
| opnd_c | input | 64 | Multiplier C |
| opnd_b | input | 64 | Addend B |
| fused_raw | input | 64 | Un-negated fused value from the arithmetic core |
| res_q | output | 64 | Final result with sign applied |
| res_vld | output | 1 | Result strobe |
| res_single | output | 1 | Decoded operation was a single form |
| op_invalid | output | 1 | Summary invalid flag for this result |
| cur_snan | output | 1 | Signalling-NaN bit of this result |
| cur_imz | output | 1 | Zero-times-infinity bit of this result |
| cur_isi | output | 1 | Infinity-minus-infinity bit of this result |
| stk_snan | output | 1 | Sticky signalling-NaN bit |
| stk_imz | output | 1 | Sticky zero-times-infinity bit |
| stk_isi | output | 1 | Sticky infinity-minus-infinity bit |

## Verification
The assertions check the following on every cycle:
- the sticky set never loses a bit without a clear or reset;
- a clear alone empties it;
- an illegal word changes nothing;
- infinity-minus-infinity and zero-times-infinity never appear together;
- a NaN fused value reaches the output untouched;
- the summary flag only appears with a result strobe.

The actual decision for each operation can only be shown by the bench's scenarios, which compare against an independent model. This covers the sign-XOR rule for the add and subtract forms, the class boundaries between quiet and signalling NaNs, denormals and signed zeros, and the sign flip on negated forms.

// File: rtl/fma_su_pkg.sv
// Shared types for the fused multiply-add exception stage.
// Assumes IEEE-754 binary interchange layout: sign, exponent, fraction.
package fma_su_pkg;

    typedef enum logic [1:0] {
        K_MADD  = 2'd0,
        K_MSUB  = 2'd1,
        K_NMADD = 2'd2,
        K_NMSUB = 2'd3
    } fma_kind_e;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_inf;
        logic is_nan;
        logic is_snan;
    } fp_class_t;

    typedef struct packed {
        logic snan;
        logic imz;
        logic isi;
    } inv_bits_t;

    function automatic logic kind_is_sub(fma_kind_e k);
        return (k == K_MSUB) || (k == K_NMSUB);
    endfunction

    function automatic logic kind_is_neg(fma_kind_e k);
        return (k == K_NMADD) || (k == K_NMSUB);
    endfunction

endpackage

// File: rtl/fp_classify.sv
// Classifies one floating-point value into zero / infinity / NaN / signalling NaN.
// Assumes: a NaN is signalling when the fraction MSB is clear; denormals are
// neither zero nor special.
module fp_classify
    import fma_su_pkg::*;
#(
    parameter int unsigned FP_W  = 64,
    parameter int unsigned EXP_W = 11
) (
    input  logic [FP_W-1:0] val,
    output fp_class_t       cls
);
    localparam int unsigned FRAC_W = FP_W - 1 - EXP_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones, exp_zero, frac_zero;

    // Field split and class decision.
    always_comb begin
        exp_f       = val[FP_W-2 -: EXP_W];
        frac_f      = val[FRAC_W-1:0];
        exp_ones    = &exp_f;
        exp_zero    = (exp_f == '0);
        frac_zero   = (frac_f == '0);
        cls.sign    = val[FP_W-1];
        cls.is_zero = exp_zero & frac_zero;
        cls.is_inf  = exp_ones & frac_zero;
        cls.is_nan  = exp_ones & ~frac_zero;
        cls.is_snan = exp_ones & ~frac_zero & ~frac_f[FRAC_W-1];
    end

endmodule

// File: rtl/fma_op_decode.sv
// Decodes an A-form instruction word into a fused multiply-add kind.
// Assumes big-endian field numbering: primary opcode in [31:26], extended
// opcode in [5:1]. Register fields and the record bit are not used here.
module fma_op_decode
    import fma_su_pkg::*;
#(
    parameter logic [5:0] PRIM_DBL = 6'd63,
    parameter logic [5:0] PRIM_SGL = 6'd59,
    parameter logic [4:0] XO_MADD  = 5'd29,
    parameter logic [4:0] XO_MSUB  = 5'd28,
    parameter logic [4:0] XO_NMADD = 5'd31,
    parameter logic [4:0] XO_NMSUB = 5'd30
) (
    input  logic [31:0] insn,
    output logic        legal,
    output logic        single,
    output fma_kind_e   kind
);
    logic [5:0] prim;
    logic [4:0] xo;
    logic       prim_hit, xo_hit;
    logic       unused_fields;

    assign unused_fields = ^{insn[25:6], insn[0]};

    // Primary and extended opcode match.
    always_comb begin
        prim     = insn[31:26];
        xo       = insn[5:1];
        prim_hit = (prim == PRIM_DBL) || (prim == PRIM_SGL);
        single   = (prim == PRIM_SGL);
        xo_hit   = 1'b1;
        kind     = K_MADD;
        unique case (xo)
            XO_MADD:  kind = K_MADD;
            XO_MSUB:  kind = K_MSUB;
            XO_NMADD: kind = K_NMADD;
            XO_NMSUB: kind = K_NMSUB;
            default:  xo_hit = 1'b0;
        endcase
        legal = prim_hit & xo_hit;
    end

endmodule

// File: rtl/fma_invalid_detect.sv
// Finds the invalid-operation cases of a fused multiply-add from operand
// classes only: signalling NaN inputs, zero times infinity, and infinity minus
// infinity using the exact product sign (XOR of A and C signs).
// Assumes: classes come from fp_classify.
module fma_invalid_detect
    import fma_su_pkg::*;
(
    input  fp_class_t cls_a,
    input  fp_class_t cls_c,
    input  fp_class_t cls_b,
    input  fma_kind_e kind,
    output inv_bits_t bits,
    output logic      prod_inf,
    output logic      prod_sign
);
    logic sub_op, sign_match;
    logic unused_b;

    assign unused_b = ^{cls_b.is_zero, cls_b.is_nan};

    // Product class and sign derived from operands, never from a product value.
    always_comb begin
        prod_inf  = (cls_a.is_inf | cls_c.is_inf)
                  & ~cls_a.is_zero & ~cls_c.is_zero
                  & ~cls_a.is_nan  & ~cls_c.is_nan;
        prod_sign = cls_a.sign ^ cls_c.sign;
    end

    // Invalid sub-bits for the multiply step and the add step.
    always_comb begin
        sub_op     = kind_is_sub(kind);
        sign_match = (prod_sign == cls_b.sign);
        bits.snan  = cls_a.is_snan | cls_c.is_snan | cls_b.is_snan;
        bits.imz   = (cls_a.is_inf & cls_c.is_zero) | (cls_a.is_zero & cls_c.is_inf);
        bits.isi   = prod_inf & cls_b.is_inf & (sub_op ? sign_match : ~sign_match);
    end

    // An infinite product rules out zero times infinity in the same operation.
    always_comb begin
        a_r3_isi_excludes_imz: assert (!(bits.isi && bits.imz))
            else $error("isi and imz raised together");
    end

endmodule

// File: rtl/fma_sign_apply.sv
// Applies the final sign flip for negated kinds; a NaN passes unchanged.
// Assumes: raw is the un-negated fused value in the same format as operands.
module fma_sign_apply
    import fma_su_pkg::*;
#(
    parameter int unsigned FP_W  = 64,
    parameter int unsigned EXP_W = 11
) (
    input  logic [FP_W-1:0] raw,
    input  fma_kind_e       kind,
    output logic [FP_W-1:0] res,
    output logic            raw_is_nan
);
    localparam int unsigned FRAC_W = FP_W - 1 - EXP_W;

    // NaN test and conditional sign inversion.
    always_comb begin
        raw_is_nan = (&raw[FP_W-2 -: EXP_W]) && (raw[FRAC_W-1:0] != '0);
        res        = raw;
        if (kind_is_neg(kind) && !raw_is_nan)
            res[FP_W-1] = ~raw[FP_W-1];
    end

endmodule

// File: rtl/fma_special_unit.sv
// Exception and sign stage of the fused multiply-add family.
// Decodes the instruction, classifies A, C, B, detects invalid operations,
// applies the sign of negated forms, registers the result one cycle after a
// legal strobe and keeps sticky exception bits.
// Assumes: fused_raw is valid in the same cycle as op_valid; synchronous
// active-low reset; clr_sticky wins over old sticky contents only.
module fma_special_unit
    import fma_su_pkg::*;
#(
    parameter int unsigned FP_W  = 64,
    parameter int unsigned EXP_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic            clr_sticky,
    input  logic [31:0]     insn_word,
    input  logic [FP_W-1:0] opnd_a,
    input  logic [FP_W-1:0] opnd_c,
    input  logic [FP_W-1:0] opnd_b,
    input  logic [FP_W-1:0] fused_raw,
    output logic [FP_W-1:0] res_q,
    output logic            res_vld,
    output logic            res_single,
    output logic            op_invalid,
    output logic            cur_snan,
    output logic            cur_imz,
    output logic            cur_isi,
    output logic            stk_snan,
    output logic            stk_imz,
    output logic            stk_isi
);
    localparam int unsigned N_OPND = 3;

    logic                       dec_legal, dec_single;
    fma_kind_e                  dec_kind;
    logic [N_OPND-1:0][FP_W-1:0] opnds;
    fp_class_t                  cls [N_OPND];
    inv_bits_t                  inv_now, stk_q, stk_d, cur_q;
    logic                       prod_inf, prod_sign;
    logic [FP_W-1:0]            res_d;
    logic                       raw_nan;
    logic                       upd;

    assign opnds = {opnd_b, opnd_c, opnd_a};
    assign upd   = op_valid & dec_legal;

    fma_op_decode u_dec (
        .insn   (insn_word),
        .legal  (dec_legal),
        .single (dec_single),
        .kind   (dec_kind)
    );

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
        fp_classify #(.FP_W(FP_W), .EXP_W(EXP_W)) u_cls (
            .val (opnds[gi]),
            .cls (cls[gi])
        );
    end

    fma_invalid_detect u_det (
        .cls_a     (cls[0]),
        .cls_c     (cls[1]),
        .cls_b     (cls[2]),
        .kind      (dec_kind),
        .bits      (inv_now),
        .prod_inf  (prod_inf),
        .prod_sign (prod_sign)
    );

    fma_sign_apply #(.FP_W(FP_W), .EXP_W(EXP_W)) u_sgn (
        .raw        (fused_raw),
        .kind       (dec_kind),
        .res        (res_d),
        .raw_is_nan (raw_nan)
    );

    // Next sticky set: optional clear, then OR in the new operation's bits.
    always_comb begin
        stk_d = clr_sticky ? '0 : stk_q;
        if (upd) stk_d = stk_d | inv_now;
    end

    // Result and per-operation flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q      <= '0;
            res_vld    <= 1'b0;
            res_single <= 1'b0;
            op_invalid <= 1'b0;
            cur_q      <= '0;
        end else begin
            res_vld    <= upd;
            op_invalid <= upd & (|inv_now);
            cur_q      <= upd ? inv_now : '0;
            if (upd) begin
                res_q      <= res_d;
                res_single <= dec_single;
            end
        end
    end

    // Sticky exception register.
    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign cur_snan = cur_q.snan;
    assign cur_imz  = cur_q.imz;
    assign cur_isi  = cur_q.isi;
    assign stk_snan = stk_q.snan;
    assign stk_imz  = stk_q.imz;
    assign stk_isi  = stk_q.isi;

    // R9: a sticky bit never drops without a clear.
    a_r9_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_sticky |=> ((stk_q & $past(stk_q)) == $past(stk_q)));

    // R9: a lone clear empties the sticky set.
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sticky && !op_valid) |=> (stk_q == '0));

    // R1: an illegal strobe leaves sticky state and result strobe quiet.
    a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dec_legal && !clr_sticky) |=> ($stable(stk_q) && !res_vld));

    // R7: a NaN fused value reaches the output unchanged.
    a_r7_nan_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && raw_nan) |=> (res_q == $past(fused_raw)));

    // R10: the summary flag only accompanies a result strobe.
    a_r10_inv_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
        op_invalid |-> res_vld);

    // R5: an add-step invalid needs an infinite product whose sign opposes an infinite B.
    a_r5_add_isi_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && inv_now.isi && !kind_is_sub(dec_kind)) |-> (prod_inf && (prod_sign != opnd_b[FP_W-1])));

endmodule

// File: tb/fma_special_unit_tb.sv
module fma_special_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        clr_sticky = 1'b0;
    logic [31:0] insn_word = '0;
    logic [63:0] opnd_a = '0, opnd_c = '0, opnd_b = '0, fused_raw = '0;
    logic [63:0] res_q;
    logic        res_vld, res_single, op_invalid;
    logic        cur_snan, cur_imz, cur_isi, stk_snan, stk_imz, stk_isi;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done = 0;
    logic [2:0]  m_stk = '0;   // {snan, imz, isi}

    always #10 clk = ~clk;     // 50 MHz

    fma_special_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .clr_sticky(clr_sticky),
        .insn_word(insn_word), .opnd_a(opnd_a), .opnd_c(opnd_c), .opnd_b(opnd_b),
        .fused_raw(fused_raw), .res_q(res_q), .res_vld(res_vld),
        .res_single(res_single), .op_invalid(op_invalid),
        .cur_snan(cur_snan), .cur_imz(cur_imz), .cur_isi(cur_isi),
        .stk_snan(stk_snan), .stk_imz(stk_imz), .stk_isi(stk_isi)
    );

    localparam logic [63:0] P_INF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] P_ONE = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;

    function automatic bit f_inf(logic [63:0] v);  return v[62:52] == 11'h7FF && v[51:0] == 0; endfunction
    function automatic bit f_nan(logic [63:0] v);  return v[62:52] == 11'h7FF && v[51:0] != 0; endfunction
    function automatic bit f_snan(logic [63:0] v); return f_nan(v) && !v[51]; endfunction
    function automatic bit f_zero(logic [63:0] v); return v[62:0] == 0; endfunction

    function automatic logic [31:0] mk_insn(logic [5:0] prim, logic [4:0] xo);
        return {prim, 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), xo, 1'($urandom)};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Applies one cycle of stimulus and checks outputs one edge later.
    task automatic apply(logic [31:0] iw, logic [63:0] a, logic [63:0] c,
                         logic [63:0] b, logic [63:0] raw, bit vld, bit clr);
        bit legal, single, sub, neg, pinf, isi, imz, snan, match;
        logic [63:0] exp_res;
        insn_word = iw; opnd_a = a; opnd_c = c; opnd_b = b; fused_raw = raw;
        op_valid = vld; clr_sticky = clr;
        single = (iw[31:26] == 6'd59);
        legal  = (iw[31:26] == 6'd63 || single) && (iw[5:1] >= 5'd28);
        sub    = (iw[5:1] == 5'd28) || (iw[5:1] == 5'd30);
        neg    = (iw[5:1] == 5'd31) || (iw[5:1] == 5'd30);
        snan   = f_snan(a) || f_snan(c) || f_snan(b);
        imz    = (f_inf(a) && f_zero(c)) || (f_zero(a) && f_inf(c));
        pinf   = (f_inf(a) || f_inf(c)) && !f_zero(a) && !f_zero(c) && !f_nan(a) && !f_nan(c);
        match  = ((a[63] != c[63]) == b[63]);
        isi    = pinf && f_inf(b) && (sub ? match : !match);
        exp_res = (neg && !f_nan(raw)) ? {~raw[63], raw[62:0]} : raw;
        legal  = legal && vld;
        if (clr) m_stk = '0;
        if (legal) m_stk = m_stk | {snan, imz, isi};
        @(negedge clk);
        op_valid = 0; clr_sticky = 0;
        chk(res_vld == legal, "R1/R8 res_vld", 64'(res_vld), 64'(legal));
        if (legal) begin
            chk(res_q == exp_res, neg ? "R7 negated result" : "R7 plain result", res_q, exp_res);
            chk(res_single == single, "R12 single flag", 64'(res_single), 64'(single));
            chk(cur_snan == snan, "R2 snan bit", 64'(cur_snan), 64'(snan));
            chk(cur_imz == imz, "R3 imz bit", 64'(cur_imz), 64'(imz));
            chk(cur_isi == isi, sub ? "R6 sub isi bit" : "R5 add isi bit R4", 64'(cur_isi), 64'(isi));
            chk(op_invalid == (snan | imz | isi), "R10 summary", 64'(op_invalid), 64'(snan | imz | isi));
        end
        chk({stk_snan, stk_imz, stk_isi} == m_stk, "R9 sticky set", 64'({stk_snan, stk_imz, stk_isi}), 64'(m_stk));
    endtask

    function automatic logic [63:0] pick_val();
        logic [63:0] r = {$urandom, $urandom};
        case ($urandom % 10)
            0: return {1'($urandom), 63'd0};
            1: return {1'($urandom), 11'h7FF, 52'd0};
            2: return {1'($urandom), 11'h7FF, 1'b1, r[50:0]};
            3: return {1'($urandom), 11'h7FF, 1'b0, r[50:1], 1'b1};
            4: return {1'($urandom), P_ONE[62:0]};
            5: return {1'($urandom), 11'd0, r[51:1], 1'b1};
            6: return {1'($urandom), 11'h7FF, 1'b0, 51'd0};   // infinity: frac zero
            default: return r;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk({res_q, res_vld, res_single, op_invalid, cur_snan, cur_imz, cur_isi,
             stk_snan, stk_imz, stk_isi} == '0, "R11 reset", res_q, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: msub with infinite product and same-sign infinite B
        apply(mk_insn(6'd63, 5'd28), P_INF, P_ONE, P_INF, QNAN, 1, 0);
        // R7: negative multiply-add with a NaN fused value keeps the sign
        apply(mk_insn(6'd63, 5'd31), QNAN, P_ONE, P_ONE, QNAN, 1, 0);
        apply(mk_insn(6'd59, 5'd30), P_ONE, P_ONE, P_ONE, {1'b1, QNAN[62:0]}, 1, 0);
        // R5: madd, +inf * -1 + +inf
        apply(mk_insn(6'd63, 5'd29), P_INF, {1'b1, P_ONE[62:0]}, P_INF, QNAN, 1, 1);
        // R5: madd with same-sign infinities is not invalid
        apply(mk_insn(6'd63, 5'd29), N_INF, {1'b1, P_ONE[62:0]}, P_INF, P_INF, 1, 1);
        // R3 and R4: zero times infinity, product not infinite so no isi
        apply(mk_insn(6'd59, 5'd28), {1'b1, 63'd0}, P_INF, P_INF, QNAN, 1, 0);
        // R4: NaN operand makes product non-infinite
        apply(mk_insn(6'd63, 5'd28), QNAN, P_INF, P_INF, QNAN, 1, 1);
        // R2: signalling NaN in B only; quiet NaN boundary in A
        apply(mk_insn(6'd63, 5'd29), QNAN, P_ONE, SNAN, QNAN, 1, 0);
        // R1: illegal primary and extended opcodes leave state alone
        apply(mk_insn(6'd31, 5'd29), SNAN, P_INF, P_INF, P_ONE, 1, 0);
        apply(mk_insn(6'd63, 5'd18), SNAN, P_INF, P_INF, P_ONE, 1, 0);
        // R9: clear alone, then clear with a legal strobe in the same cycle
        apply(mk_insn(6'd63, 5'd29), P_ONE, P_ONE, P_ONE, P_ONE, 0, 1);
        apply(mk_insn(6'd63, 5'd29), SNAN, P_ONE, P_ONE, QNAN, 1, 0);
        apply(mk_insn(6'd63, 5'd30), P_INF, P_ONE, N_INF, QNAN, 1, 1);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] pr = ($urandom % 8 == 0) ? 6'($urandom) : (($urandom % 2) ? 6'd63 : 6'd59);
            logic [4:0] xo = ($urandom % 8 == 0) ? 5'($urandom) : 5'(28 + $urandom % 4);
            apply(mk_insn(pr, xo), pick_val(), pick_val(), pick_val(), pick_val(),
                  ($urandom % 5) != 0, ($urandom % 16) == 0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule